// File: doc/BRIEF.md
# Debug Transport DMI Access Controller

This block sits behind a JTAG test access port and owns two of its data registers: the transport control/status word and the debug-module access register. The port's state machine hands it capture, shift and update strobes together with the current instruction code and the serial input. The block returns the serial output of whichever of its two registers is selected. Shifting is least significant bit first: each shift cycle moves serial input into the top bit and presents bit 0 on the serial output.

A debugger scans an access word made of address, data and operation into the access register. At update time the block turns a read or a write into a single request on a valid/ready request port. A response port then returns read data and an error flag. The next capture of the access register reports the address of the last request, the last read data and a two-bit status. Error and busy status are sticky and lock out further traffic until the debugger clears them through the control/status register. A stronger clear also abandons a request that may never be answered.

Top module: `dtm_dmi_ctrl`

## Requirements
- R1: Instruction code 0x10 selects the control/status register and 0x11 selects the access register. For any other code the serial output is 0, and the strobes neither issue a request nor change status.
- R2: The access register is ABITS+34 bits wide, with the operation in bits 1:0, data in bits 33:2 and the address in bits ABITS+33:34. It shifts least significant bit first. Capture loads the last request's address, the last read data and the current status, and all three are 0 after reset.
- R3: A capture of the control/status register returns 1 in bits 3:0, ABITS in bits 9:4, the sticky status in bits 11:10 and IDLE_HINT in bits 14:12. All other bits are 0.
- R4: An update with operation 1 (read), while the status is clear and nothing is outstanding, issues one request carrying op 1 and the address. Its response data is reported at the next capture with status 0.
- R5: An update with operation 2 (write) issues one request carrying op 2, the address and the data. A write response leaves the reported data unchanged.
- R6: Operation 0 (and the unused code 3) sends nothing on the request port and never changes the status.
- R7: A capture or an update of the access register while a request is still outstanding reports status 3 (busy), which becomes sticky. Such an update issues nothing.
- R8: A response with its error flag set makes the status 2 (error), which is sticky.
- R9: While the status is non-zero, updates of the access register issue no request.
- R10: An update of the control/status register with bit 16 set clears the sticky status and leaves an outstanding request to complete normally.
- R11: An update of the control/status register with bit 17 set clears the sticky status and abandons any outstanding request. A response that arrives afterwards changes neither the data nor the status.
- R12: The request port keeps valid, op, address and data stable until the handshake, and drops valid after exactly one accepted handshake per issued operation.
- R13: After reset no request is pending, the request port is idle and the status is 0.
- R14: A debugger that spends IDLE_HINT cycles between an update and the next capture never sees busy, provided the module answers within the bound the hint was sized for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_code | input | IR_W | Current instruction code |
| capture_dr | input | 1 | Capture strobe for the selected data register |
| shift_dr | input | 1 | Shift enable, one bit per cycle |
| update_dr | input | 1 | Update strobe for the selected data register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the selected register) |
| dmi_req_valid | output | 1 | Request valid |
| dmi_req_ready | input | 1 | Request accepted by the debug module |
| dmi_req_op | output | 2 | Request operation, 1 read, 2 write |
| dmi_req_addr | output | ABITS | Request address |
| dmi_req_data | output | 32 | Write data |
| dmi_rsp_valid | input | 1 | Response strobe, single cycle |
| dmi_rsp_data | input | 32 | Response read data |
| dmi_rsp_err | input | 1 | Response error flag |

## Verification
The hardest case to reach is a response that arrives after a hard reset has abandoned its request. The request has to be accepted, and its answer has to be held back longer than a full 32-bit control/status scan takes. The bench gives its responder model a long forced latency for one read. It issues the hard reset while that read is in flight, waits past the delayed answer, and then confirms that the captured data and status did not move. Busy and error are reached the same way, by capturing too early against an in-flight request and by reading an address the responder answers with an error.

// File: rtl/dtm_pkg.sv
// Shared encodings for the debug transport access controller.
// Assumes a 2-bit operation field and a 2-bit status field.
package dtm_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_RSV = 2'd3
    } dmi_op_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_RSV  = 2'd1,
        ST_ERR  = 2'd2,
        ST_BUSY = 2'd3
    } dmi_stat_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_REQ  = 2'd1,
        ENG_WAIT = 2'd2
    } eng_state_e;

    localparam int DATA_W    = 32;
    localparam int CS_W      = 32;
    localparam int CS_CLR_B  = 16;
    localparam int CS_HARD_B = 17;
endpackage

// File: rtl/dtm_shift_chain.sv
// Generic capture/shift register for one test data register.
// Capture loads a parallel value. Shift moves tdi into the top bit and
// drops bit 0, so the caller reads bit 0 as the serial output.
// Assumes capture and shift are never high in the same cycle.
module dtm_shift_chain #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] cap_val,
    input  logic         shift,
    input  logic         tdi,
    output logic [W-1:0] q
);
    // Parallel load on capture, one-bit right shift on shift.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (cap)   q <= cap_val;
        else if (shift) q <= {tdi, q[W-1:1]};
    end
endmodule

// File: rtl/dtm_dmi_engine.sv
// Request/response engine for debug-module accesses.
// It issues one valid/ready request per accepted read or write and keeps
// the sticky busy/error status, the last request address and the last
// read data. A hard reset abandons the outstanding request.
// Assumes capture, update and the two clears never coincide, and that
// responses are single-cycle strobes without back-pressure.
module dtm_dmi_engine
    import dtm_pkg::*;
#(
    parameter int ABITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_dmi,
    input  logic              upd_dmi,
    input  logic [1:0]        upd_op,
    input  logic [ABITS-1:0]  upd_addr,
    input  logic [DATA_W-1:0] upd_data,
    input  logic              clr_sticky,
    input  logic              hard_rst,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [1:0]        req_op,
    output logic [ABITS-1:0]  req_addr,
    output logic [DATA_W-1:0] req_data,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_err,
    output logic [1:0]        sticky,
    output logic [1:0]        cap_status,
    output logic [ABITS-1:0]  last_addr,
    output logic [DATA_W-1:0] rdata
);
    eng_state_e state;
    logic       pending;
    logic       op_valid;

    assign pending   = (state != ENG_IDLE);
    assign op_valid  = (upd_op == OP_RD) || (upd_op == OP_WR);
    assign req_valid = (state == ENG_REQ);

    // Status presented at capture: sticky first, then live busy.
    always_comb begin
        if (sticky != ST_OK) cap_status = sticky;
        else if (pending)    cap_status = ST_BUSY;
        else                 cap_status = ST_OK;
    end

    // Sequencing of requests, responses, sticky status and clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ENG_IDLE;
            sticky    <= ST_OK;
            req_op    <= OP_NOP;
            req_addr  <= '0;
            req_data  <= '0;
            last_addr <= '0;
            rdata     <= '0;
        end else if (hard_rst) begin
            state  <= ENG_IDLE;
            sticky <= ST_OK;
        end else begin
            if (state == ENG_REQ && req_ready) state <= ENG_WAIT;
            if (state == ENG_WAIT && rsp_valid) begin
                state <= ENG_IDLE;
                if (rsp_err) begin
                    if (sticky == ST_OK) sticky <= ST_ERR;
                end else if (req_op == OP_RD) begin
                    rdata <= rsp_data;
                end
            end
            if (cap_dmi && pending && sticky == ST_OK) sticky <= ST_BUSY;
            if (upd_dmi && sticky == ST_OK) begin
                if (pending) begin
                    sticky <= ST_BUSY;
                end else if (op_valid) begin
                    state     <= ENG_REQ;
                    req_op    <= upd_op;
                    req_addr  <= upd_addr;
                    req_data  <= upd_data;
                    last_addr <= upd_addr;
                end
            end
            if (clr_sticky) sticky <= ST_OK;
        end
    end

    // R12: request fields hold until accepted
    a_r12_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !hard_rst) |=>
        (req_valid && $stable(req_op) && $stable(req_addr) && $stable(req_data)));

    // R12: one handshake per issued operation
    a_r12_one_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    // R6: a no-operation update leaves port and status quiet
    a_r6_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_dmi && !op_valid && !pending && sticky == ST_OK) |=>
        (!req_valid && sticky == ST_OK));

    // R9: a sticky status blocks new requests
    a_r9_sticky_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_dmi && sticky != ST_OK && !pending) |=> !req_valid);

    // R8: sticky status holds until a clear
    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky != ST_OK && !clr_sticky && !hard_rst) |=> $stable(sticky));

    // R11: hard reset drops the request and the status
    a_r11_hard_reset: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst |=> (!req_valid && sticky == ST_OK));
endmodule

// File: rtl/dtm_dmi_ctrl.sv
// Top of the debug transport access controller. It decodes the
// instruction code, holds the control/status and access shift chains,
// turns control/status updates into sticky clears or a hard reset, and
// drives the serial output from the selected chain.
// Assumes TAP strobes are single-cycle pulses in the clk domain.
module dtm_dmi_ctrl
    import dtm_pkg::*;
#(
    parameter int            IR_W      = 5,
    parameter logic [IR_W-1:0] IR_CS   = 5'h10,
    parameter logic [IR_W-1:0] IR_DMI  = 5'h11,
    parameter int            ABITS     = 7,
    parameter int            IDLE_HINT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IR_W-1:0]   ir_code,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic              dmi_req_valid,
    input  logic              dmi_req_ready,
    output logic [1:0]        dmi_req_op,
    output logic [ABITS-1:0]  dmi_req_addr,
    output logic [DATA_W-1:0] dmi_req_data,
    input  logic              dmi_rsp_valid,
    input  logic [DATA_W-1:0] dmi_rsp_data,
    input  logic              dmi_rsp_err
);
    localparam int DMI_W    = ABITS + DATA_W + 2;
    localparam int DATA_LSB = 2;
    localparam int ADDR_LSB = DATA_W + 2;

    logic              sel_cs, sel_dmi;
    logic [CS_W-1:0]   cs_q, cs_cap;
    logic [DMI_W-1:0]  dmi_q, dmi_cap;
    logic [1:0]        sticky, cap_status;
    logic [ABITS-1:0]  last_addr;
    logic [DATA_W-1:0] rdata;
    logic              cs_upd, clr_sticky, hard_rst;
    logic              unused_cs_bits;

    assign sel_cs  = (ir_code == IR_CS);
    assign sel_dmi = (ir_code == IR_DMI);

    assign cs_upd     = update_dr && sel_cs;
    assign clr_sticky = cs_upd && cs_q[CS_CLR_B];
    assign hard_rst   = cs_upd && cs_q[CS_HARD_B];
    assign unused_cs_bits = ^{cs_q[CS_W-1:CS_HARD_B+1], cs_q[CS_CLR_B-1:0]};

    // Control/status capture word: version, address width, status, idle hint.
    always_comb begin
        cs_cap        = '0;
        cs_cap[3:0]   = 4'd1;
        cs_cap[9:4]   = 6'(ABITS);
        cs_cap[11:10] = sticky;
        cs_cap[14:12] = 3'(IDLE_HINT);
    end

    // Access capture word: last address, last read data, status.
    assign dmi_cap = {last_addr, rdata, cap_status};

    dtm_shift_chain #(.W(CS_W)) u_cs_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (capture_dr && sel_cs),
        .cap_val (cs_cap),
        .shift   (shift_dr && sel_cs),
        .tdi     (tdi),
        .q       (cs_q)
    );

    dtm_shift_chain #(.W(DMI_W)) u_dmi_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (capture_dr && sel_dmi),
        .cap_val (dmi_cap),
        .shift   (shift_dr && sel_dmi),
        .tdi     (tdi),
        .q       (dmi_q)
    );

    dtm_dmi_engine #(.ABITS(ABITS)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_dmi    (capture_dr && sel_dmi),
        .upd_dmi    (update_dr && sel_dmi),
        .upd_op     (dmi_q[1:0]),
        .upd_addr   (dmi_q[ADDR_LSB +: ABITS]),
        .upd_data   (dmi_q[DATA_LSB +: DATA_W]),
        .clr_sticky (clr_sticky),
        .hard_rst   (hard_rst),
        .req_valid  (dmi_req_valid),
        .req_ready  (dmi_req_ready),
        .req_op     (dmi_req_op),
        .req_addr   (dmi_req_addr),
        .req_data   (dmi_req_data),
        .rsp_valid  (dmi_rsp_valid),
        .rsp_data   (dmi_rsp_data),
        .rsp_err    (dmi_rsp_err),
        .sticky     (sticky),
        .cap_status (cap_status),
        .last_addr  (last_addr),
        .rdata      (rdata)
    );

    // Serial output from the selected chain, 0 when neither is selected.
    always_comb begin
        if (sel_cs)       tdo = cs_q[0];
        else if (sel_dmi) tdo = dmi_q[0];
        else              tdo = 1'b0;
    end
endmodule

// File: tb/dtm_dmi_ctrl_tb.sv
module dtm_dmi_ctrl_tb;
    localparam int ABITS = 7;
    localparam int IDLE  = 6;
    localparam int DMIW  = ABITS + 34;
    localparam logic [ABITS-1:0] ERR_ADDR = 7'h7F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] ir_code = 5'h00;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic tdo;
    logic dmi_req_valid, dmi_req_ready;
    logic [1:0] dmi_req_op;
    logic [ABITS-1:0] dmi_req_addr;
    logic [31:0] dmi_req_data;
    logic dmi_rsp_valid, dmi_rsp_err;
    logic [31:0] dmi_rsp_data;

    int errors = 0, checks = 0;
    int hs_count = 0;
    int force_lat = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dtm_dmi_ctrl #(.ABITS(ABITS), .IDLE_HINT(IDLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .ir_code(ir_code),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo),
        .dmi_req_valid(dmi_req_valid), .dmi_req_ready(dmi_req_ready),
        .dmi_req_op(dmi_req_op), .dmi_req_addr(dmi_req_addr),
        .dmi_req_data(dmi_req_data),
        .dmi_rsp_valid(dmi_rsp_valid), .dmi_rsp_data(dmi_rsp_data),
        .dmi_rsp_err(dmi_rsp_err)
    );

    // Responder model: random ready, bounded latency, small memory.
    logic [31:0] resp_mem [16];
    logic [31:0] model_mem [16];
    int   cnt = 0, stall = 0;
    logic [1:0] r_op;
    logic [ABITS-1:0] r_addr;

    initial begin
        for (int i = 0; i < 16; i++) begin
            resp_mem[i]  = 32'hA500_0000 | 32'(i * 32'h0101_0107);
            model_mem[i] = resp_mem[i];
        end
        dmi_req_ready = 0; dmi_rsp_valid = 0; dmi_rsp_err = 0; dmi_rsp_data = '0;
    end

    always @(posedge clk) begin
        if (dmi_req_valid && dmi_req_ready) begin
            hs_count <= hs_count + 1;
            r_op   <= dmi_req_op;
            r_addr <= dmi_req_addr;
            cnt    <= (force_lat != 0) ? force_lat : 1 + int'($urandom % 2);
            if (dmi_req_op == 2'd2 && dmi_req_addr != ERR_ADDR)
                resp_mem[dmi_req_addr[3:0]] <= dmi_req_data;
            dmi_rsp_valid <= 1'b0;
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                dmi_rsp_valid <= 1'b1;
                dmi_rsp_err   <= (r_addr == ERR_ADDR);
                dmi_rsp_data  <= (r_op == 2'd1) ? resp_mem[r_addr[3:0]] : 32'hDEAD_BEEF;
            end else dmi_rsp_valid <= 1'b0;
        end else dmi_rsp_valid <= 1'b0;
        stall <= (dmi_req_valid && !dmi_req_ready) ? stall + 1 : 0;
        dmi_req_ready <= ($urandom % 2 == 1) || (stall >= 1) ||
                         (dmi_req_valid && !dmi_req_ready);
    end

    function automatic logic [63:0] pack(input logic [ABITS-1:0] a,
                                         input logic [31:0] d, input logic [1:0] op);
        return 64'({a, d, op});
    endfunction

    function automatic logic [63:0] cs_word(input logic [1:0] st);
        logic [31:0] w = '0;
        w[3:0] = 4'd1; w[9:4] = 6'(ABITS); w[11:10] = st; w[14:12] = 3'(IDLE);
        return 64'(w);
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scan(input logic [4:0] ir, input logic [63:0] din,
                        input int n, output logic [63:0] dout);
        dout = '0;
        @(negedge clk); ir_code = ir; capture_dr = 1;
        @(negedge clk); capture_dr = 0;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo; tdi = din[i]; shift_dr = 1;
            @(negedge clk);
        end
        shift_dr = 0; update_dr = 1;
        @(negedge clk); update_dr = 0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    logic [63:0] q;
    logic [ABITS-1:0] e_addr;
    logic [31:0] e_data;
    logic [1:0]  e_st;
    int hs0;

    // Watchdog: an expired run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13: idle port after reset
        check(64'(dmi_req_valid), 64'd0, "R13 req idle");
        // R2/R13: access capture all zero; R3 status word
        scan(5'h11, 64'd0, DMIW, q); check(q, 64'd0, "R2 R13 reset capture");
        scan(5'h10, 64'd0, 32, q);   check(q, cs_word(2'd0), "R3 status word");

        // R5 then R4: write then read back
        hs0 = hs_count;
        scan(5'h11, pack(7'd5, 32'h1234_5678, 2'd2), DMIW, q); idle(IDLE);
        model_mem[5] = 32'h1234_5678;
        scan(5'h11, pack(7'd5, 32'h0, 2'd1), DMIW, q); idle(IDLE);
        check(q, pack(7'd5, 32'h0, 2'd0), "R5 write leaves data");
        scan(5'h11, 64'd0, DMIW, q); idle(IDLE);
        check(q, pack(7'd5, 32'h1234_5678, 2'd0), "R4 read data");
        check(64'(hs_count - hs0), 64'd2, "R12 one handshake per op");

        // R6: nop sends nothing; unused code 3 as well
        hs0 = hs_count;
        scan(5'h11, pack(7'd9, 32'h5, 2'd3), DMIW, q); idle(IDLE);
        scan(5'h11, 64'd0, DMIW, q); idle(IDLE);
        check(q, pack(7'd5, 32'h1234_5678, 2'd0), "R6 nop capture");
        check(64'(hs_count - hs0), 64'd0, "R6 nop no request");

        // R1: unselected code gives zero output and no effect
        scan(5'h01, {64{1'b1}}, DMIW, q); idle(IDLE);
        check(q, 64'd0, "R1 unselected tdo");
        check(64'(hs_count - hs0), 64'd0, "R1 no request");

        // R7: early capture gives busy, sticky; R10 clear keeps request
        scan(5'h11, pack(7'd2, 32'h0, 2'd1), DMIW, q);
        scan(5'h11, pack(7'd3, 32'h0, 2'd1), DMIW, q); idle(IDLE);
        check(64'(q[1:0]), 64'd3, "R7 busy on early capture");
        scan(5'h10, 64'd0, 32, q);
        check(q, cs_word(2'd3), "R7 busy sticky in status word");
        scan(5'h10, 64'(1) << 16, 32, q); idle(IDLE);
        scan(5'h10, 64'd0, 32, q);
        check(q, cs_word(2'd0), "R10 clear");
        scan(5'h11, 64'd0, DMIW, q); idle(IDLE);
        check(q, pack(7'd2, model_mem[2], 2'd0), "R10 request completed");

        // R8 error sticky; R9 updates ignored while set
        scan(5'h11, pack(ERR_ADDR, 32'h0, 2'd1), DMIW, q); idle(IDLE);
        hs0 = hs_count;
        scan(5'h11, pack(7'd1, 32'hCAFE_0001, 2'd2), DMIW, q); idle(IDLE);
        check(64'(q[1:0]), 64'd2, "R8 error status");
        check(64'(hs_count - hs0), 64'd0, "R9 ignored while sticky");
        scan(5'h11, 64'd0, DMIW, q); idle(IDLE);
        check(64'(q[1:0]), 64'd2, "R8 error holds");
        scan(5'h10, 64'(1) << 16, 32, q); idle(IDLE);

        // R11: hard reset abandons a slow read; late answer dropped
        force_lat = 80;
        scan(5'h11, pack(7'd4, 32'h0, 2'd1), DMIW, q); idle(3);
        force_lat = 0;
        scan(5'h10, 64'(1) << 17, 32, q);
        check(64'(dmi_req_valid), 64'd0, "R11 request dropped");
        idle(100);
        scan(5'h10, 64'd0, 32, q);
        check(q, cs_word(2'd0), "R11 status clear");
        scan(5'h11, 64'd0, DMIW, q); idle(IDLE);
        check(q, pack(7'd4, model_mem[2], 2'd0), "R11 late response dropped");

        // R4/R5/R14: random traffic spaced by the idle hint
        e_addr = 7'd4; e_data = model_mem[2]; e_st = 2'd0;
        for (int it = 0; it < 80; it++) begin
            logic [1:0] op;
            logic [ABITS-1:0] a;
            logic [31:0] d;
            op = 2'($urandom % 4);
            a  = ($urandom % 8 == 0) ? ERR_ADDR : 7'($urandom % 16);
            d  = $urandom;
            scan(5'h11, pack(a, d, op), DMIW, q);
            check(q, pack(e_addr, e_data, e_st), "R14 R4 random capture");
            if (e_st != 2'd0) begin
                scan(5'h10, 64'(1) << 16, 32, q);
                e_st = 2'd0;
            end else if (op == 2'd1 || op == 2'd2) begin
                e_addr = a;
                if (a == ERR_ADDR) e_st = 2'd2;
                else if (op == 2'd1) e_data = model_mem[a[3:0]];
                else model_mem[a[3:0]] = d;
            end
            idle(IDLE);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule